// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers five interrupt requests (two external request lines, two timer overflow flags and one serial-controller request). It masks each request with its own enable bit and with a master enable. It sorts the surviving requests into a high and a low priority level and offers the CPU one winner at a time. The CPU opens an accept window with `take_ok`. The block answers with a one-cycle acknowledge, carrying a fixed vector address and a one-hot source tag so the requesting source can clear its flag.

The enable and priority registers sit on a small register bus. Each can be written as a whole byte at its byte address, or one bit at a time at a bit address whose low three bits select the bit. Unimplemented bits read as 1 and keep that value whatever is written. An in-service flag per level records which routines are running. A return pulse from the CPU clears the flag of the highest running level.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all source enables, the master enable and all priority bits are 0; the enable byte (address A8h) reads 60h, the priority byte (address B8h) reads E0h, and `irq_ack` is low.
- R2: A byte write to A8h loads source enables from data bits 4..0 and the master enable from bit 7. A byte write to B8h loads the priorities from bits 4..0 (1 = high). Enable bits 6..5 and priority bits 7..5 always read 1 and ignore writes.
- R3: A bit write sets or clears one bit, with its value taken from `reg_wdata[0]`. Addresses A8h+k (k=0..4) target source enable k, AFh targets the master enable, and B8h+k targets priority k. Bit writes to ADh, AEh, BDh..BFh have no effect.
- R4: A request is granted only when its source enable and the master enable are both 1.
- R5: Source index i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial) is granted with vector 0003h + 8*i and `irq_src` bit i set alone.
- R6: Among eligible requests of the same level, the lowest index wins.
- R7: When requests are eligible at both levels, a high-level request wins.
- R8: A high-level request is granted while a low-level routine is in service.
- R9: No request is granted while a high-level routine is in service, and no low-level request is granted while a low-level routine is in service.
- R10: A `reti` pulse clears the high in-service flag if it is set, and otherwise the low one.
- R11: A grant happens only in a cycle where `take_ok` is 1. `irq_ack` then rises in the next cycle for exactly one cycle, together with `irq_vec` and `irq_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 5 | Request levels, index order as in R5 |
| take_ok | input | 1 | CPU accepts an interrupt this cycle |
| reti | input | 1 | Return-from-interrupt pulse |
| reg_addr | input | 8 | Byte address for byte access, bit address for bit writes |
| reg_wdata | input | 8 | Write data; bit 0 is the value for bit writes |
| reg_wr_byte | input | 1 | Byte write strobe |
| reg_wr_bit | input | 1 | Bit write strobe |
| reg_rdata | output | 8 | Read data for the byte at `reg_addr` |
| irq_pend | output | 1 | A request could be granted now |
| irq_ack | output | 1 | One-cycle grant acknowledge |
| irq_vec | output | 16 | Vector address of the grant |
| irq_src | output | 5 | One-hot granted source |

## Verification
Some properties are checked on every cycle: an acknowledge always carries a one-hot source tag whose vector matches its index, and that source was enabled under the master enable. No acknowledge follows a cycle with a high routine in service, and a return clears the high flag. The unimplemented bits also read as 1 at all times. Only the bench scenarios can show the fixed order within a level, preemption of a low routine, which level a return clears, and the byte and bit write decoding with its readback values.

// File: rtl/irq_pkg.sv
// Shared constants for the two-level interrupt controller.
// Assumes: sources are indexed in fixed priority order, index 0 first.
package irq_pkg;
    localparam int NUM_SRC   = 5;
    localparam int VEC_W     = 16;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam logic [7:0] EN_BYTE_ADDR  = 8'hA8;
    localparam logic [7:0] PRI_BYTE_ADDR = 8'hB8;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam logic [VEC_W-1:0] VEC_STEP = 16'h0008;

    typedef enum logic [0:0] {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } irq_level_e;
endpackage

// File: rtl/irq_regs.sv
// Enable and priority registers with byte and bit write decoding.
// Assumes: bit addresses share the upper five bits with their byte address,
// and the low three bits pick the bit. Unimplemented bits read 1.
module irq_regs
    import irq_pkg::*;
#(
    parameter int          N_SRC    = NUM_SRC,
    parameter logic [7:0]  EN_ADDR  = EN_BYTE_ADDR,
    parameter logic [7:0]  PRI_ADDR = PRI_BYTE_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_wr_byte,
    input  logic             reg_wr_bit,
    output logic [7:0]       reg_rdata,
    output logic [N_SRC-1:0] src_en,
    output logic             glob_en,
    output logic [N_SRC-1:0] src_pri
);
    localparam int GLOB_BIT = 7;

    logic       hit_en_byte, hit_pri_byte, hit_en_bit, hit_pri_bit;
    logic [2:0] bit_sel;
    logic [7:0] en_view, pri_view;

    // Decode which register and which bit the bus access targets.
    always_comb begin
        hit_en_byte  = reg_wr_byte && (reg_addr == EN_ADDR);
        hit_pri_byte = reg_wr_byte && (reg_addr == PRI_ADDR);
        hit_en_bit   = reg_wr_bit  && (reg_addr[7:3] == EN_ADDR[7:3]);
        hit_pri_bit  = reg_wr_bit  && (reg_addr[7:3] == PRI_ADDR[7:3]);
        bit_sel      = reg_addr[2:0];
    end

    // Per-source enable and priority flops, one generate slice per source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_en[i]  <= 1'b0;
                src_pri[i] <= 1'b0;
            end else begin
                if (hit_en_byte)
                    src_en[i] <= reg_wdata[i];
                else if (hit_en_bit && (bit_sel == 3'(i)))
                    src_en[i] <= reg_wdata[0];
                if (hit_pri_byte)
                    src_pri[i] <= reg_wdata[i];
                else if (hit_pri_bit && (bit_sel == 3'(i)))
                    src_pri[i] <= reg_wdata[0];
            end
        end
    end

    // Master enable flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (hit_en_byte)
            glob_en <= reg_wdata[GLOB_BIT];
        else if (hit_en_bit && (bit_sel == 3'(GLOB_BIT)))
            glob_en <= reg_wdata[0];
    end

    // Build the readback bytes; unimplemented positions read 1.
    always_comb begin
        en_view  = 8'hFF;
        pri_view = 8'hFF;
        for (int i = 0; i < N_SRC; i++) begin
            en_view[i]  = src_en[i];
            pri_view[i] = src_pri[i];
        end
        en_view[GLOB_BIT] = glob_en;
    end

    // Read multiplexer on the byte address.
    always_comb begin
        if (reg_addr == EN_ADDR)
            reg_rdata = en_view;
        else if (reg_addr == PRI_ADDR)
            reg_rdata = pri_view;
        else
            reg_rdata = 8'h00;
    end

    AST_UNIMP_EN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == EN_ADDR) |-> (reg_rdata[6:5] == 2'b11)); // R2
    AST_UNIMP_PRI_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == PRI_ADDR) |-> (reg_rdata[7:5] == 3'b111)); // R2
endmodule

// File: rtl/irq_arbiter.sv
// Combinational two-level arbiter with fixed lowest-index-first order.
// Assumes: in-service flags come from irq_inservice; a running high routine
// blocks all, a running low routine blocks only the low level.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int I_W   = IDX_W
) (
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] src_pri,
    input  logic             in_hi,
    input  logic             in_lo,
    output logic             cand_valid,
    output logic [I_W-1:0]   cand_idx,
    output irq_level_e       cand_lvl
);
    logic [N_SRC-1:0] eligible, hi_set, lo_set;
    logic [I_W-1:0]   hi_idx, lo_idx;

    // Mask requests with enables and split them by level.
    always_comb begin
        eligible = src_req & src_en & {N_SRC{glob_en}};
        hi_set   = eligible & src_pri;
        lo_set   = eligible & ~src_pri;
    end

    // Pick the lowest set index in each level.
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_set[i]) hi_idx = I_W'(i);
            if (lo_set[i]) lo_idx = I_W'(i);
        end
    end

    // Choose a level honouring the running routines.
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        cand_lvl   = LVL_LOW;
        if (!in_hi) begin
            if (|hi_set) begin
                cand_valid = 1'b1;
                cand_idx   = hi_idx;
                cand_lvl   = LVL_HIGH;
            end else if (!in_lo && (|lo_set)) begin
                cand_valid = 1'b1;
                cand_idx   = lo_idx;
                cand_lvl   = LVL_LOW;
            end
        end
    end
endmodule

// File: rtl/irq_inservice.sv
// Tracks which priority levels have a routine running.
// Assumes: a grant and a return in one cycle apply return first, grant last.
module irq_inservice
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant,
    input  irq_level_e grant_lvl,
    input  logic       reti,
    output logic       in_hi,
    output logic       in_lo
);
    logic nxt_hi, nxt_lo;

    // Compute next flags: return clears the top level, then grant sets.
    always_comb begin
        nxt_hi = in_hi;
        nxt_lo = in_lo;
        if (reti) begin
            if (in_hi) nxt_hi = 1'b0;
            else       nxt_lo = 1'b0;
        end
        if (grant) begin
            if (grant_lvl == LVL_HIGH) nxt_hi = 1'b1;
            else                       nxt_lo = 1'b1;
        end
    end

    // Register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hi <= 1'b0;
            in_lo <= 1'b0;
        end else begin
            in_hi <= nxt_hi;
            in_lo <= nxt_lo;
        end
    end

    AST_RETI_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_hi && !grant) |=> !in_hi); // R10
    AST_RETI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_hi && in_lo) |=> in_lo); // R10
endmodule

// File: rtl/irq_ctrl.sv
// Top of the interrupt controller: registers, arbiter, in-service tracker
// and the registered grant stage that presents vector and acknowledge.
// Assumes: sources hold requests until they see their irq_src bit.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int V_W   = VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             take_ok,
    input  logic             reti,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_wr_byte,
    input  logic             reg_wr_bit,
    output logic [7:0]       reg_rdata,
    output logic             irq_pend,
    output logic             irq_ack,
    output logic [V_W-1:0]   irq_vec,
    output logic [N_SRC-1:0] irq_src
);
    localparam int I_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] src_en, src_pri;
    logic             glob_en, in_hi, in_lo;
    logic             cand_valid, grant;
    logic [I_W-1:0]   cand_idx;
    irq_level_e       cand_lvl;

    irq_regs #(.N_SRC(N_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr_byte(reg_wr_byte),
        .reg_wr_bit (reg_wr_bit),
        .reg_rdata  (reg_rdata),
        .src_en     (src_en),
        .glob_en    (glob_en),
        .src_pri    (src_pri)
    );

    irq_arbiter #(.N_SRC(N_SRC), .I_W(I_W)) u_arb (
        .src_req   (src_req),
        .src_en    (src_en),
        .glob_en   (glob_en),
        .src_pri   (src_pri),
        .in_hi     (in_hi),
        .in_lo     (in_lo),
        .cand_valid(cand_valid),
        .cand_idx  (cand_idx),
        .cand_lvl  (cand_lvl)
    );

    // A grant needs a candidate and an open accept window.
    always_comb begin
        grant    = cand_valid && take_ok;
        irq_pend = cand_valid;
    end

    irq_inservice u_isv (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .grant_lvl(cand_lvl),
        .reti     (reti),
        .in_hi    (in_hi),
        .in_lo    (in_lo)
    );

    // Register the grant: one-cycle acknowledge with vector and source tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ack <= 1'b0;
            irq_vec <= '0;
            irq_src <= '0;
        end else begin
            irq_ack <= grant;
            if (grant) begin
                irq_vec <= V_W'(VEC_BASE) + V_W'(VEC_STEP) * V_W'(cand_idx);
                irq_src <= N_SRC'(1) << cand_idx;
            end else begin
                irq_src <= '0;
            end
        end
    end

    AST_ACK_ONEHOT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $onehot(irq_src)); // R5
    AST_NO_TAG_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |-> (irq_src == '0)); // R11
    AST_ACK_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !take_ok |=> !irq_ack); // R11
    AST_ACK_VEC_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (((irq_vec - V_W'(VEC_BASE)) % V_W'(VEC_STEP)) == '0)
                    && (irq_src == (N_SRC'(1) << ((irq_vec - V_W'(VEC_BASE)) / V_W'(VEC_STEP))))); // R5
    AST_ACK_SOURCE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(glob_en) && ((irq_src & $past(src_en)) != '0))); // R4
    AST_HIGH_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_hi |=> !irq_ack); // R9
endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_req = '0;
    logic       take_ok = 1'b0;
    logic       reti = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr_byte = 1'b0;
    logic       reg_wr_bit = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_pend, irq_ack;
    logic [15:0] irq_vec;
    logic [4:0] irq_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed { logic [15:0] vec; logic [4:0] src; } exp_t;
    exp_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .take_ok(take_ok),
        .reti(reti), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr_byte(reg_wr_byte), .reg_wr_bit(reg_wr_bit),
        .reg_rdata(reg_rdata), .irq_pend(irq_pend), .irq_ack(irq_ack),
        .irq_vec(irq_vec), .irq_src(irq_src)
    );

    // Monitor: pop expected grants and compare as acknowledges appear.
    always @(negedge clk) begin
        if (rst_n && irq_ack) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected grant vec=%h src=%b expected none", irq_vec, irq_src);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (irq_vec !== e.vec || irq_src !== e.src) begin
                    failures++;
                    $display("FAIL %s vec=%h src=%b expected vec=%h src=%b",
                             t, irq_vec, irq_src, e.vec, e.src);
                end
            end
        end
    end

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_byte = 1'b1;
        @(negedge clk);
        reg_wr_byte = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic v);
        reg_addr = a; reg_wdata = {7'b0, v}; reg_wr_bit = 1'b1;
        @(negedge clk);
        reg_wr_bit = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check_eq(tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    // Driver: open one accept window; push the expected grant if any.
    task automatic try_grant(input string tag, input bit expect_one, input int idx);
        if (expect_one) begin
            exp_q.push_back('{vec: 16'h0003 + 16'(8 * idx), src: 5'(1 << idx)});
            tag_q.push_back(tag);
        end
        take_ok = 1'b1;
        @(negedge clk);
        take_ok = 1'b0;
        if (!expect_one)
            check_eq(tag, {15'b0, irq_ack}, 16'h0000);
        @(negedge clk);
        if (expect_one)
            check_eq({tag, " ack one cycle"}, {15'b0, irq_ack}, 16'h0000);
    endtask

    task automatic ret_pulse();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 enable byte after reset", 8'hA8, 8'h60);
        rd_check("R1 priority byte after reset", 8'hB8, 8'hE0);
        check_eq("R1 ack low after reset", {15'b0, irq_ack}, 16'h0000);

        // R2 byte writes and unimplemented bits
        wr_byte(8'hA8, 8'hFF);
        rd_check("R2 enable all ones", 8'hA8, 8'hFF);
        wr_byte(8'hA8, 8'h00);
        rd_check("R2 enable unimplemented stay 1", 8'hA8, 8'h60);
        wr_byte(8'hB8, 8'h15);
        rd_check("R2 priority byte", 8'hB8, 8'hF5);
        wr_byte(8'hB8, 8'h00);

        // R3 bit writes
        wr_bit(8'hAF, 1'b1);
        wr_bit(8'hA9, 1'b1);
        rd_check("R3 bit set master and enable 1", 8'hA8, 8'hE2);
        wr_bit(8'hAD, 1'b0);
        wr_bit(8'hAE, 1'b0);
        rd_check("R3 bit write to unimplemented ignored", 8'hA8, 8'hE2);
        wr_bit(8'hBC, 1'b1);
        rd_check("R3 bit set priority 4", 8'hB8, 8'hF0);
        wr_bit(8'hBC, 1'b0);
        wr_bit(8'hA9, 1'b0);
        rd_check("R3 bit clear", 8'hA8, 8'hE0);

        // R4 enable gating
        wr_byte(8'hA8, 8'h1F);
        src_req = 5'b00001;
        try_grant("R4 master enable off", 1'b0, 0);
        wr_byte(8'hA8, 8'h9E);
        try_grant("R4 source enable off", 1'b0, 0);
        wr_byte(8'hA8, 8'h9F);
        try_grant("R4 R5 external 0 vector", 1'b1, 0);
        src_req = 5'b00000;
        ret_pulse();

        // R11 no grant without accept window
        src_req = 5'b00100;
        repeat (4) @(negedge clk);
        check_eq("R11 no ack without take_ok", {15'b0, irq_ack}, 16'h0000);
        src_req = 5'b00000;

        // R6 same-level order, R9 low blocks low
        src_req = 5'b11110;
        try_grant("R6 R5 timer 0 first", 1'b1, 1);
        try_grant("R9 low blocks low", 1'b0, 0);
        src_req[1] = 1'b0; ret_pulse();
        try_grant("R6 R5 external 1 next", 1'b1, 2);
        src_req[2] = 1'b0; ret_pulse();
        try_grant("R6 R5 timer 1 next", 1'b1, 3);
        src_req[3] = 1'b0; ret_pulse();
        try_grant("R6 R5 serial last", 1'b1, 4);
        src_req[4] = 1'b0; ret_pulse();

        // R7 high beats low, R9 high blocks everything
        wr_byte(8'hB8, 8'h10);
        src_req = 5'b10001;
        try_grant("R7 high serial wins", 1'b1, 4);
        src_req[4] = 1'b0;
        try_grant("R9 high blocks low", 1'b0, 0);
        ret_pulse();
        try_grant("R10 low granted after return", 1'b1, 0);
        src_req[0] = 1'b0;

        // R8 preemption, R10 return clears high first
        src_req[4] = 1'b1;
        try_grant("R8 high preempts low", 1'b1, 4);
        src_req[4] = 1'b0;
        ret_pulse();
        src_req[2] = 1'b1;
        try_grant("R10 low still in service", 1'b0, 2);
        ret_pulse();
        try_grant("R10 low cleared by second return", 1'b1, 2);
        src_req = 5'b00000;
        ret_pulse();

        repeat (2) @(negedge clk);
        check_eq("R11 all expected grants seen", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule